// File: doc/BRIEF.md
# Wishbone Parallel Flash Read Bridge

This block is a Wishbone slave that answers 32-bit reads from an external asynchronous NOR flash with a 16-bit data bus. Each bus read becomes two flash accesses. The lower halfword is read first, then the upper one. The two halves are packed into one 32-bit word, which is returned with a single-cycle acknowledge. The flash strobes are active low. Output enable is held low for a parameterised number of clocks, so the flash access time is met at any bus clock rate.

The acknowledge acts as the ready half of the handshake. A master that raises cycle and strobe must hold its request until it sees the acknowledge, so the master is stalled for the whole of both flash accesses. When the master also holds its lock line, consecutive reads form a block. Chip enable then stays asserted between beats, and only output enable is pulsed. Writes are not passed to the flash. They are acknowledged and otherwise ignored.

Top module: `fbr_flash_read_bridge`

## Requirements
- R1: While reset is active and after it is released, `wb_ack_o` is 0, `wb_dat_o` is 0, and `fl_ce_no` and `fl_oe_no` are both 1.
- R2: A read is accepted only when `wb_cyc_i`=1, `wb_stb_i`=1 and `wb_we_i`=0. `fl_oe_no` is low only while `fl_ce_no` is low.
- R3: Each halfword access holds `fl_oe_no` low for exactly WAIT_CYCLES clocks before its data is captured. For a read request first presented from idle, `wb_ack_o` is high in clock cycle 2*WAIT_CYCLES+3, counting the cycle in which the request is presented as cycle 0.
- R4: The lower halfword is read from flash word address {wb_adr_i[FL_AW:2],0} and the upper halfword from {wb_adr_i[FL_AW:2],1}. `wb_dat_o` = {upper, lower}. Address bits 1:0 and the bits above FL_AW have no effect.
- R5: `wb_ack_o` is a single-cycle pulse for each transfer.
- R6: `fl_adr_o` is stable while `fl_oe_no` is low. Output enable returns high for at least one cycle before the flash address changes.
- R7: `wb_dat_o` keeps the last word read and changes only in the cycle in which `wb_ack_o` is high.
- R8: While `wb_cyc_i` and `wb_lock_i` stay high, `fl_ce_no` stays low between consecutive read beats. After an unlocked read, `fl_ce_no` is high in the following idle cycle.
- R9: A write request (`wb_we_i`=1) from idle is acknowledged in the next cycle. `fl_we_no` stays 1, chip enable is not asserted, and `wb_dat_o` is unchanged.
- R10: If `wb_cyc_i` or `wb_stb_i` drops during a flash access, the bridge returns to idle in the next cycle with both strobes high and issues no acknowledge. A following read completes normally.
- R11: `fl_word_mode_o` is held at 1, which selects 16-bit word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Transfer strobe |
| wb_we_i | input | 1 | Write enable (1 = write) |
| wb_lock_i | input | 1 | Locked block transfer |
| wb_adr_i | input | WB_AW | Byte address |
| wb_dat_o | output | 2*FL_DW | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| fl_adr_o | output | FL_AW | Flash word address |
| fl_dq_i | input | FL_DW | Flash data |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low (held high) |
| fl_word_mode_o | output | 1 | Byte/word select, 1 = word mode |

## Verification
The assertions check on every cycle the properties that hold at any instant:
- the acknowledge is a single-cycle pulse;
- output enable is never low without chip enable;
- the flash address does not move while output enable is low;
- the returned word changes only with the acknowledge;
- an abort releases both strobes at once;
- a write is acknowledged one cycle after it is presented.

Other behaviours are shown only by the bench scenarios:
- the halfword ordering and the packed data values against a modelled flash;
- the exact latency of a read;
- chip enable staying low across a locked block;
- a write leaving the data unchanged;
- recovery after an aborted read.

// File: rtl/fbr_pkg.sv
`timescale 1ns/1ps
package fbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACCESS = 2'd2,
    ST_ACK    = 2'd3
  } fbr_state_t;
endpackage

// File: rtl/fbr_wait_timer.sv
`timescale 1ns/1ps
module fbr_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned CW = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
  localparam logic [CW-1:0] LAST_VAL = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == LAST_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || last_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the count never passes the programmed access length
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_VAL);

  // R3: the counter restarts from zero on each new access
  assert_cnt_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/fbr_word_pack.sv
`timescale 1ns/1ps
module fbr_word_pack #(
  parameter int unsigned LANE_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cap_lo_i,
  input  logic                  cap_hi_i,
  input  logic [LANE_W-1:0]     lane_i,
  output logic [2*LANE_W-1:0]   word_o
);
  logic [LANE_W-1:0]   lo_q;
  logic [2*LANE_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      word_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= lane_i;
      if (cap_hi_i) word_q <= {lane_i, lo_q};
    end
  end

  assign word_o = word_q;

  // R4: the two halves are never captured in the same cycle
  assert_one_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_lo_i && cap_hi_i));

  // R4: the packed word moves only when the upper half is taken
  assert_word_on_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_hi_i |=> $stable(word_q));
endmodule

// File: rtl/fbr_flash_read_bridge.sv
`timescale 1ns/1ps
module fbr_flash_read_bridge
  import fbr_pkg::*;
#(
  parameter int unsigned WB_AW       = 32,
  parameter int unsigned FL_DW       = 16,
  parameter int unsigned FL_AW       = 20,
  parameter int unsigned WAIT_CYCLES = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic                 wb_lock_i,
  input  logic [WB_AW-1:0]     wb_adr_i,
  output logic [2*FL_DW-1:0]   wb_dat_o,
  output logic                 wb_ack_o,
  output logic [FL_AW-1:0]     fl_adr_o,
  input  logic [FL_DW-1:0]     fl_dq_i,
  output logic                 fl_ce_no,
  output logic                 fl_oe_no,
  output logic                 fl_we_no,
  output logic                 fl_word_mode_o
);
  localparam int unsigned IDX_W = FL_AW - 1;

  fbr_state_t       state_q;
  logic             half_q;
  logic             keep_ce_q;
  logic             ack_rd_q;
  logic [FL_AW-1:0] fadr_q;
  logic             last_w;
  logic             active_w;
  logic             rd_req_w;
  logic             wr_req_w;
  logic             cap_lo_w;
  logic             cap_hi_w;
  logic [IDX_W-1:0] word_idx_w;
  logic             unused_adr;

  assign active_w   = wb_cyc_i && wb_stb_i;
  assign rd_req_w   = active_w && !wb_we_i;
  assign wr_req_w   = active_w && wb_we_i;
  assign word_idx_w = wb_adr_i[FL_AW:2];
  assign unused_adr = ^{wb_adr_i[WB_AW-1:FL_AW+1], wb_adr_i[1:0]};

  fbr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == ST_ACCESS),
    .last_o (last_w)
  );

  assign cap_lo_w = (state_q == ST_ACCESS) && active_w && last_w && !half_q;
  assign cap_hi_w = (state_q == ST_ACCESS) && active_w && last_w &&  half_q;

  fbr_word_pack #(.LANE_W(FL_DW)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_lo_i (cap_lo_w),
    .cap_hi_i (cap_hi_w),
    .lane_i   (fl_dq_i),
    .word_o   (wb_dat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      half_q    <= 1'b0;
      keep_ce_q <= 1'b0;
      ack_rd_q  <= 1'b0;
      fadr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          keep_ce_q <= keep_ce_q && wb_cyc_i && wb_lock_i;
          if (rd_req_w) begin
            fadr_q   <= {word_idx_w, 1'b0};
            half_q   <= 1'b0;
            ack_rd_q <= 1'b1;
            state_q  <= ST_GAP;
          end else if (wr_req_w) begin
            ack_rd_q <= 1'b0;
            state_q  <= ST_ACK;
          end
        end
        ST_GAP: begin
          if (!active_w) begin
            keep_ce_q <= 1'b0;
            state_q   <= ST_IDLE;
          end else begin
            state_q <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (!active_w) begin
            keep_ce_q <= 1'b0;
            state_q   <= ST_IDLE;
          end else if (last_w) begin
            if (!half_q) begin
              half_q  <= 1'b1;
              fadr_q  <= {fadr_q[FL_AW-1:1], 1'b1};
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          keep_ce_q <= wb_cyc_i && wb_lock_i && (ack_rd_q || keep_ce_q);
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wb_ack_o       = (state_q == ST_ACK);
  assign fl_adr_o       = fadr_q;
  assign fl_oe_no       = !(state_q == ST_ACCESS);
  assign fl_ce_no       = !((state_q == ST_GAP) || (state_q == ST_ACCESS) ||
                            ((state_q == ST_ACK) && ack_rd_q) ||
                            ((state_q == ST_IDLE) && keep_ce_q));
  assign fl_we_no       = 1'b1;
  assign fl_word_mode_o = 1'b1;

  // R5: acknowledge lasts exactly one cycle
  assert_ack_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);

  // R2: output enable only under chip enable
  assert_oe_under_ce_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_ce_no);

  // R6: address held while output enable stays low
  assert_adr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_oe_no && !$past(fl_oe_no)) |-> $stable(fl_adr_o));

  // R7: returned word changes only alongside the acknowledge
  assert_dat_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wb_dat_o) |-> wb_ack_o);

  // R10: an abort releases both strobes on the next cycle
  assert_abort_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_GAP || state_q == ST_ACCESS) && !active_w) |=> (fl_ce_no && fl_oe_no && !wb_ack_o));

  // R9: a write from idle is acknowledged one cycle later
  assert_write_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && wr_req_w) |=> (wb_ack_o && fl_oe_no));

  // R3: a read acknowledge always follows a flash access cycle
  assert_ack_after_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wb_ack_o) && ack_rd_q) |-> !$past(fl_oe_no));
endmodule

// File: tb/sim_fbr_flash_read_bridge.sv
`timescale 1ns/1ps
module sim_fbr_flash_read_bridge;
  localparam int W   = 12;
  localparam int FAW = 20;
  localparam int RD_LAT  = 2*W + 3;
  localparam int BLK_LAT = 2*W + 4;
  localparam logic [31:0] VEC [0:5] = '{
    32'h0000_0000, 32'h0000_0004, 32'h001F_FFFC,
    32'h0000_1236, 32'hFFF0_0008, 32'h0008_0010
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0, lock = 1'b0;
  logic [31:0] adr = '0;
  logic [31:0] dat;
  logic ack;
  logic [FAW-1:0] fadr;
  logic [15:0] dq;
  logic ce_n, oe_n, we_n, wmode;

  int tests = 0, fails = 0;
  int oe_run = 0, short_err = 0, adr_err = 0, ce_gap = 0;
  logic mon_ce = 1'b0, abort_ok = 1'b0;
  logic [FAW-1:0] prev_adr = '0;

  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [FAW-1:0] a);
    return a[15:0] ^ {a[19:16], 12'h000} ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [FAW-1:0] base;
    base = {a[FAW:2], 1'b0};
    return {pat(base | 1), pat(base)};
  endfunction

  assign dq = (!ce_n && !oe_n) ? pat(fadr) : 16'hBAD0;

  fbr_flash_read_bridge #(.WAIT_CYCLES(W), .FL_AW(FAW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_lock_i(lock), .wb_adr_i(adr), .wb_dat_o(dat), .wb_ack_o(ack),
    .fl_adr_o(fadr), .fl_dq_i(dq), .fl_ce_no(ce_n), .fl_oe_no(oe_n),
    .fl_we_no(we_n), .fl_word_mode_o(wmode)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!oe_n) begin
        if (oe_run > 0 && fadr !== prev_adr) adr_err++;
        oe_run++;
      end else begin
        if (oe_run > 0 && oe_run != W && !abort_ok) short_err++;
        oe_run = 0;
      end
      prev_adr = fadr;
      if (mon_ce && ce_n) ce_gap++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic rd(input logic [31:0] a, input logic lk, output logic [31:0] d, output int lat);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a; lock = lk; lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 100);
    d = dat;
  endtask

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    int lat;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 ack in reset", {31'b0, ack}, 32'h0);
    chk("R1 dat in reset", dat, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", {30'b0, ce_n, oe_n}, 32'h3);
    chk("R11 word mode pin", {31'b0, wmode}, 32'h1);

    // R3 R4 R7 R8 vector walk of single reads
    foreach (VEC[i]) begin
      @(negedge clk);
      rd(VEC[i], 1'b0, d, lat);
      stb = 1'b0; cyc = 1'b0;
      chk("R4 packed data", d, exp_word(VEC[i]));
      chk("R3 read latency", lat, RD_LAT);
      @(negedge clk);
      chk("R7 data held after ack", dat, exp_word(VEC[i]));
      chk("R8 ce released after unlocked read", {31'b0, ce_n}, 32'h1);
      chk("R5 ack single cycle", {31'b0, ack}, 32'h0);
    end

    // R8 locked block of three beats
    @(negedge clk);
    rd(32'h0000_0100, 1'b1, d, lat);
    chk("R4 block beat 0", d, exp_word(32'h0000_0100));
    mon_ce = 1'b1;
    rd(32'h0000_0104, 1'b1, d, lat);
    chk("R4 block beat 1", d, exp_word(32'h0000_0104));
    chk("R8 block beat latency", lat, BLK_LAT);
    rd(32'h0000_0108, 1'b1, d, lat);
    chk("R4 block beat 2", d, exp_word(32'h0000_0108));
    mon_ce = 1'b0;
    stb = 1'b0; cyc = 1'b0; lock = 1'b0;
    chk("R8 ce held across locked beats", ce_gap, 0);
    @(negedge clk);

    // R9 write ignored
    @(negedge clk);
    prev = dat;
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 32'h0000_0040;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 100);
    chk("R9 write ack latency", lat, 1);
    chk("R9 no chip enable on write", {30'b0, ce_n, we_n}, 32'h3);
    chk("R9 data unchanged by write", dat, prev);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R9 data still unchanged", dat, prev);

    // R10 abort mid access
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 32'h0000_0200;
    repeat (5) @(negedge clk);
    abort_ok = 1'b1;
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
    chk("R10 strobes released on abort", {30'b0, ce_n, oe_n}, 32'h3);
    chk("R10 no ack on abort", {31'b0, ack}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R10 still no ack", {31'b0, ack}, 32'h0);
    abort_ok = 1'b0;
    rd(32'h0000_0200, 1'b0, d, lat);
    stb = 1'b0; cyc = 1'b0;
    chk("R10 read after abort", d, exp_word(32'h0000_0200));
    chk("R2 read after abort latency", lat, RD_LAT);

    // R3 R6 monitor results
    chk("R6 address stable under output enable", adr_err, 0);
    chk("R3 output enable length", short_err, 0);

    // R1 reset mid access
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; adr = 32'h0000_0300;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 data cleared by reset", dat, 32'h0);
    chk("R1 strobes high in reset", {29'b0, ce_n, oe_n, ack}, 32'h6);
    cyc = 1'b0; stb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 word mode after reset", {31'b0, wmode}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule